// File: doc/BRIEF.md
# Vector Length Setting Unit

This block executes the instruction that fixes the working vector length of a single-issue core. When a strobe accompanies a 32-bit instruction word, the unit confirms the primary opcode and the sub-opcode. It then picks a requested length and a maximum length, clamps the first to the second, and stores both in its two special registers. It can also write the clamped length to a general-purpose register and update condition field 0. A typical strip-mined loop issues the instruction once per pass, reads back the granted element count, and subtracts that count from the work left.

The register file read port is simple. The unit presents the source register index combinationally, and the core returns the 64-bit contents on an operand input within the same cycle. Every result is registered and appears one clock after the strobe.

Top module: `vlen_set_unit`

## Requirements
- R1: A strobed word is accepted only if word[31:26] equals 19 and word[5:1] equals the SUB_OP parameter (default 27). Any other strobed word pulses `illegal_o`. It leaves `cur_len_o` and `max_len_o` unchanged and writes neither a register nor condition field 0.
- R2: Fields use big-endian bit numbering, so instruction bit k is word[31-k]. The destination index is word[25:21] and the source index is word[20:16]. The immediate is word[15:9], the length-select bit is word[7], the maximum-select bit is word[6] and the record bit is word[0]. `src_idx_o` always shows the source index.
- R3: With the length-select bit set and a zero source index, the requested length is the current length register.
- R4: With the length-select bit set and a nonzero source index, the requested length is the immediate.
- R5: With the length-select bit clear and a nonzero source index, the requested length is the 64-bit operand. An operand above 127 counts as 127.
- R6: With the length-select bit clear and a zero source index, the requested length is the current length register.
- R7: With the maximum-select bit set, the new maximum is the immediate. Otherwise the maximum register keeps its value.
- R8: The new length is the minimum of the requested length and the new maximum. Both registers take their new values.
- R9: A nonzero destination index produces a one-cycle write of the zero-extended new length to that index. A zero destination index produces no write.
- R10: With the record bit set, `cr0_o` is written as {LT,GT,EQ,SO}. LT is 0. GT is 1 when the new length is nonzero. EQ is 1 when it is zero. SO copies `so_i`. With the record bit clear, `cr0_we_o` stays low.
- R11: All results appear on the clock edge that samples the strobe. `done_o` pulses for one cycle per strobe, whether the word is legal or not.
- R12: Synchronous reset clears both length registers and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| src_idx_o | output | 5 | Source register index to the read port |
| src_data_i | input | 64 | Operand read from the source register |
| so_i | input | 1 | Summary overflow bit |
| cur_len_o | output | 7 | Current vector length register |
| max_len_o | output | 7 | Maximum vector length register |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Illegal instruction pulse |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 64 | Register write data |
| cr0_we_o | output | 1 | Condition field 0 write enable |
| cr0_o | output | 4 | Condition field 0 value {LT,GT,EQ,SO} |

## Verification
The bench builds the unit with its default parameters: 7-bit lengths, a 64-bit operand and sub-opcode 27. Because the length ceiling is only 127, random immediates and operands often land on the clamp and saturation edges. Operands at 127, 128 and far above test the saturation boundary exactly. Zero lengths occur often enough to exercise the EQ encoding of condition field 0.

// File: rtl/vls_pkg.sv
package vls_pkg;

  localparam int unsigned PRIMARY_OP = 19;

  typedef struct packed {
    logic [5:0] primary;
    logic [4:0] dst;
    logic [4:0] src;
    logic [6:0] imm;
    logic       len_sel;
    logic       max_sel;
    logic [4:0] xop;
    logic       rec;
  } vls_fields_t;

  // Instruction bit k sits at word[31-k].
  function automatic vls_fields_t vls_split(input logic [31:0] w);
    vls_fields_t f;
    f.primary = w[31:26];
    f.dst     = w[25:21];
    f.src     = w[20:16];
    f.imm     = w[15:9];
    f.len_sel = w[7];
    f.max_sel = w[6];
    f.xop     = w[5:1];
    f.rec     = w[0];
    return f;
  endfunction

endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
#(
  parameter int unsigned SUB_OP = 27
) (
  input  logic [31:0] insn_i,
  output vls_fields_t fields_o,
  output logic        legal_o
);
  localparam logic [5:0] PRIM = 6'(PRIMARY_OP);
  localparam logic [4:0] XOP  = 5'(SUB_OP);

  always_comb begin
    fields_o = vls_split(insn_i);
    legal_o  = (fields_o.primary == PRIM) && (fields_o.xop == XOP);
  end
endmodule

// File: rtl/vls_select.sv
module vls_select
  import vls_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned GPR_W = 64
) (
  input  vls_fields_t        fields_i,
  input  logic [LEN_W-1:0]   cur_len_i,
  input  logic [LEN_W-1:0]   cur_max_i,
  input  logic [GPR_W-1:0]   src_data_i,
  output logic [LEN_W-1:0]   nxt_len_o,
  output logic [LEN_W-1:0]   nxt_max_o
);
  localparam logic [LEN_W-1:0] LEN_CEIL = {LEN_W{1'b1}};

  logic [LEN_W-1:0] imm_len;
  logic [LEN_W-1:0] opnd_len;
  logic [LEN_W-1:0] req_len;
  logic             src_zero;

  always_comb begin
    imm_len  = LEN_W'(fields_i.imm);
    src_zero = (fields_i.src == '0);
    // operand saturation at the register ceiling
    if (|src_data_i[GPR_W-1:LEN_W]) opnd_len = LEN_CEIL;
    else                            opnd_len = src_data_i[LEN_W-1:0];

    if (fields_i.len_sel) req_len = src_zero ? cur_len_i : imm_len;
    else                  req_len = src_zero ? cur_len_i : opnd_len;

    nxt_max_o = fields_i.max_sel ? imm_len : cur_max_i;
    nxt_len_o = (req_len < nxt_max_o) ? req_len : nxt_max_o;
  end
endmodule

// File: rtl/vls_state.sv
module vls_state #(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned GPR_W = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             bad_i,
  input  logic [LEN_W-1:0] nxt_len_i,
  input  logic [LEN_W-1:0] nxt_max_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic             rec_i,
  input  logic             so_i,
  output logic [LEN_W-1:0] cur_len_o,
  output logic [LEN_W-1:0] max_len_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_waddr_o,
  output logic [GPR_W-1:0] rf_wdata_o,
  output logic             cr0_we_o,
  output logic [3:0]       cr0_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_len_o  <= '0;
      max_len_o  <= '0;
      done_o     <= 1'b0;
      illegal_o  <= 1'b0;
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      cr0_we_o   <= 1'b0;
      cr0_o      <= '0;
    end else begin
      done_o    <= start_i | bad_i;
      illegal_o <= bad_i;
      rf_we_o   <= start_i && (dst_i != '0);
      cr0_we_o  <= start_i && rec_i;
      if (start_i) begin
        cur_len_o  <= nxt_len_i;
        max_len_o  <= nxt_max_i;
        rf_waddr_o <= dst_i;
        rf_wdata_o <= GPR_W'(nxt_len_i);
        if (rec_i) cr0_o <= {1'b0, nxt_len_i != '0, nxt_len_i == '0, so_i};
      end
    end
  end

  AST_LEN_WITHIN_MAX: assert property (@(posedge clk) disable iff (rst)
    cur_len_o <= max_len_o); // R8
  AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($stable(cur_len_o) && $stable(max_len_o))); // R1
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!rf_we_o && !cr0_we_o)); // R1
  AST_NO_WRITE_R0: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_waddr_o != '0)); // R9
  AST_CR0_FORM: assert property (@(posedge clk) disable iff (rst)
    cr0_we_o |-> (!cr0_o[3] && $countones(cr0_o[2:1]) == 1)); // R10
  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (start_i || bad_i) |=> done_o); // R11
endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit
  import vls_pkg::*;
#(
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned GPR_W  = 64,
  parameter int unsigned SUB_OP = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [31:0]      insn_i,
  output logic [4:0]       src_idx_o,
  input  logic [GPR_W-1:0] src_data_i,
  input  logic             so_i,
  output logic [LEN_W-1:0] cur_len_o,
  output logic [LEN_W-1:0] max_len_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [GPR_W-1:0] rf_wdata_o,
  output logic             cr0_we_o,
  output logic [3:0]       cr0_o
);
  localparam int unsigned IDX_W = 5;

  vls_fields_t      fields;
  logic             legal;
  logic [LEN_W-1:0] nxt_len;
  logic [LEN_W-1:0] nxt_max;
  logic             start;
  logic             bad;

  vls_decode #(.SUB_OP(SUB_OP)) u_decode (
    .insn_i   (insn_i),
    .fields_o (fields),
    .legal_o  (legal)
  );

  vls_select #(.LEN_W(LEN_W), .GPR_W(GPR_W)) u_select (
    .fields_i   (fields),
    .cur_len_i  (cur_len_o),
    .cur_max_i  (max_len_o),
    .src_data_i (src_data_i),
    .nxt_len_o  (nxt_len),
    .nxt_max_o  (nxt_max)
  );

  assign src_idx_o = fields.src;
  assign start     = issue_i && legal;
  assign bad       = issue_i && !legal;

  vls_state #(.LEN_W(LEN_W), .GPR_W(GPR_W), .IDX_W(IDX_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .bad_i      (bad),
    .nxt_len_i  (nxt_len),
    .nxt_max_i  (nxt_max),
    .dst_i      (fields.dst),
    .rec_i      (fields.rec),
    .so_i       (so_i),
    .cur_len_o  (cur_len_o),
    .max_len_o  (max_len_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .cr0_we_o   (cr0_we_o),
    .cr0_o      (cr0_o)
  );
endmodule

// File: tb/test_vlen_set_unit.sv
`timescale 1ns/1ps
module test_vlen_set_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [31:0] insn = '0;
  logic [4:0]  src_idx;
  logic [63:0] src_data = '0;
  logic        so = 1'b0;
  logic [6:0]  cur_len, max_len;
  logic        done, illegal, rf_we, cr0_we;
  logic [4:0]  rf_waddr;
  logic [63:0] rf_wdata;
  logic [3:0]  cr0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [6:0] m_len = '0;
  logic [6:0] m_max = '0;

  always #4 clk = ~clk;

  vlen_set_unit i_vlen_set_unit (
    .clk(clk), .rst(rst), .issue_i(issue), .insn_i(insn),
    .src_idx_o(src_idx), .src_data_i(src_data), .so_i(so),
    .cur_len_o(cur_len), .max_len_o(max_len), .done_o(done),
    .illegal_o(illegal), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .cr0_we_o(cr0_we), .cr0_o(cr0)
  );

  function automatic logic [31:0] mk(input logic [5:0] prim, input logic [4:0] dst,
      input logic [4:0] src, input logic [6:0] imm, input logic ls, input logic ms,
      input logic [4:0] xop, input logic rec);
    return {prim, dst, src, imm, 1'b0, ls, ms, xop, rec};
  endfunction

  function automatic logic [6:0] sat(input logic [63:0] v);
    return (v > 64'd127) ? 7'd127 : v[6:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [63:0] d, input logic s);
    logic [6:0] req, nmax, nlen;
    logic ok, ls, ms, rec;
    logic [4:0] dst, src;
    logic [6:0] imm;
    dst = w[25:21]; src = w[20:16]; imm = w[15:9];
    ls = w[7]; ms = w[6]; rec = w[0];
    ok = (w[31:26] == 6'd19) && (w[5:1] == 5'd27);
    @(negedge clk);
    issue = 1'b1; insn = w; src_data = d; so = s;
    #1 chk("R2 src index", src_idx, src);
    if (ls) req = (src == 0) ? m_len : imm;          // R3 R4
    else    req = (src == 0) ? m_len : sat(d);       // R5 R6
    nmax = ms ? imm : m_max;                         // R7
    nlen = (req < nmax) ? req : nmax;                // R8
    @(negedge clk);
    issue = 1'b0;
    chk("R11 done", done, 1);
    chk("R1 illegal", illegal, !ok);
    if (ok) begin
      m_len = nlen; m_max = nmax;
    end
    chk("R8 length", cur_len, m_len);
    chk("R7 maximum", max_len, m_max);
    chk("R9 write enable", rf_we, ok && dst != 0);
    if (ok && dst != 0) begin
      chk("R9 write index", rf_waddr, dst);
      chk("R9 write data", rf_wdata, {57'd0, nlen});
    end
    chk("R10 cr0 enable", cr0_we, ok && rec);
    if (ok && rec) chk("R10 cr0 value", cr0, {1'b0, nlen != 0, nlen == 0, s});
    @(negedge clk);
    chk("R11 done single pulse", done, 0);
  endtask

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R12 reset length", cur_len, 0);
    chk("R12 reset max", max_len, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset write", rf_we, 0);
    // directed corner cases
    run(mk(19, 4, 1, 8, 1, 1, 27, 1), 0, 0);      // R4 R7: imm 8 for both
    run(mk(19, 5, 2, 20, 1, 0, 27, 0), 0, 0);     // R8 clamp 20 -> 8
    run(mk(19, 6, 3, 100, 0, 1, 27, 0), 64'd5, 0);   // R5 operand 5
    run(mk(19, 6, 3, 127, 0, 1, 27, 0), 64'd127, 0); // R5 edge 127
    run(mk(19, 6, 3, 127, 0, 0, 27, 1), 64'd128, 1); // R5 saturate 128
    run(mk(19, 7, 3, 127, 0, 0, 27, 0), 64'hFFFF_0000_0000_0001, 0); // R5 high bits
    run(mk(19, 1, 0, 9, 0, 1, 27, 1), 64'd3, 0);  // R6 keep current, clamp to 9
    run(mk(19, 1, 0, 2, 1, 1, 27, 1), 0, 1);      // R3 current, max 2
    run(mk(19, 0, 4, 0, 1, 1, 27, 1), 0, 0);      // R9 no write, R10 EQ
    run(mk(18, 3, 4, 50, 1, 1, 27, 1), 0, 0);     // R1 bad primary
    run(mk(19, 3, 4, 50, 1, 1, 26, 1), 0, 0);     // R1 bad sub-op
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] p; logic [4:0] x; logic [4:0] dst, src; logic [63:0] d;
      p = ($urandom % 10 == 0) ? 6'($urandom) : 6'd19;
      x = ($urandom % 10 == 0) ? 5'($urandom) : 5'd27;
      dst = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      src = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      case ($urandom % 3)
        0: d = 64'($urandom % 140);
        1: d = {$urandom, $urandom};
        default: d = 64'($urandom % 8);
      endcase
      run(mk(p, dst, src, 7'($urandom), 1'($urandom), 1'($urandom), x, 1'($urandom)),
          d, 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule